// File: doc/BRIEF.md
# Sub-Banked Cache Data Array Controller

This block drives the data storage of a single cache bank. The storage is cut into four sub-banks, and every sub-bank is cut again into twelve way panels, each panel holding the lines of one way. A request names a sub-bank, a way and a row. The controller then switches on that sub-bank and the one panel of the chosen way, and no others. It performs a 16-byte read or a byte-masked 16-byte write, and releases the enables once the array access is done.

A sub-bank that has just taken a request stays closed for one further cycle, so it takes requests at most once every two cycles. The other sub-banks stay open and can take requests in that cycle, so a stream that rotates across sub-banks runs at one request per cycle. Read data returns on a fixed eight-cycle pipeline together with the tag the requester attached. Tag lookup and way replacement are handled elsewhere. Clock gating is represented here by the enable outputs.

Top module: `cbank_data_ctrl`

## Requirements
- R1: After reset is released, and before any request, `sub_en` and `panel_en` are all zero, `rsp_valid` is low and `req_ready` is high.
- R2: In the cycle after a request is accepted, `sub_en` has exactly bit `req_sub` set and `panel_en` has exactly bit `req_sub*12 + req_way` set. Ways are numbered 0 to 11.
- R3: The enables of an access are released after one cycle. In the second cycle after acceptance, that sub-bank's `sub_en` bit and all of its panel bits are low unless a new request to it was accepted.
- R4: In the cycle after a sub-bank accepts a request, `req_ready` is low for a request naming that sub-bank. A request to it is accepted again two cycles after the first one.
- R5: In the cycle after a sub-bank accepts a request, `req_ready` is high for a request naming any other sub-bank.
- R6: A request presented while `req_ready` is low has no effect. It raises no enable, does not change stored data, and produces no response.
- R7: A read accepted in cycle c raises `rsp_valid` for exactly one cycle, in cycle c+8, with `rsp_tag` equal to its `req_tag`.
- R8: A write updates byte b (bits 8b+7..8b) of the addressed row only where `req_mask[b]` is 1. Other bytes, other ways, other rows and other sub-banks keep their contents.
- R9: Writes produce no response on `rsp_valid`.
- R10: Reads accepted on consecutive cycles, each to a different sub-bank from the previous one, return on consecutive cycles in request order, each with the data last written to its row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all enables and the response pipeline |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | The named sub-bank can accept in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sub | input | 2 | Sub-bank index |
| req_way | input | 4 | Way panel index, 0 to 11 |
| req_row | input | 4 | Row within the panel |
| req_wdata | input | 128 | Write data |
| req_mask | input | 16 | Byte write mask, bit b covers data bits 8b+7..8b |
| req_tag | input | 8 | Requester tag, returned with read data |
| sub_en | output | 4 | Per sub-bank enable |
| panel_en | output | 48 | Per panel enable, index sub*12 + way |
| rsp_valid | output | 1 | Read data valid |
| rsp_tag | output | 8 | Tag of the returning read |
| rsp_rdata | output | 128 | Read data |

## Verification
Two events can share one cycle: a sub-bank refusing a request because of its two-cycle window, and a different sub-bank being free to accept one. The bench provokes both by issuing back-to-back requests, some naming the sub-bank that was just used and others naming a different one. It also runs a streak of reads to a single sub-bank, so that refusals and acceptances alternate. A scoreboard predicts every `req_ready` value from the previous acceptance. It expects no effect and no response from a refused request. It judges each read by its arrival cycle, its tag and a byte-accurate model of the stored data.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
    localparam int WORD_W = 128;
    localparam int MASK_W = WORD_W / 8;
    localparam int TAG_W  = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // one beat travelling down the read-return pipeline
    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t data;
    } rsp_beat_t;
endpackage

// File: rtl/cbank_subctl.sv
// Per sub-bank access register: holds one access for its single active cycle.
module cbank_subctl import cbank_pkg::*; #(
    parameter int WAY_W = 4,
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WAY_W-1:0] in_way,
    input  logic [ROW_W-1:0] in_row,
    input  logic             in_wr,
    input  word_t            in_wdata,
    input  mask_t            in_mask,
    input  tag_t             in_tag,
    output logic             busy,
    output logic [WAY_W-1:0] way,
    output logic [ROW_W-1:0] row,
    output logic             wr,
    output word_t            wdata,
    output mask_t            mask,
    output tag_t             tag
);
    typedef struct packed {
        logic             busy;
        logic [WAY_W-1:0] way;
        logic [ROW_W-1:0] row;
        logic             wr;
        word_t            wdata;
        mask_t            mask;
        tag_t             tag;
    } sub_state_t;

    sub_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = 1'b0;          // access finishes after one cycle: release enables
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.way   = in_way;
            st_d.row   = in_row;
            st_d.wr    = in_wr;
            st_d.wdata = in_wdata;
            st_d.mask  = in_mask;
            st_d.tag   = in_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign way   = st_q.way;
    assign row   = st_q.row;
    assign wr    = st_q.wr;
    assign wdata = st_q.wdata;
    assign mask  = st_q.mask;
    assign tag   = st_q.tag;
endmodule

// File: rtl/cbank_panel.sv
// One way panel: byte-masked synchronous write, combinational read.
module cbank_panel import cbank_pkg::*; #(
    parameter int ROWS  = 16,
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             en,
    input  logic             wr,
    input  logic [ROW_W-1:0] row,
    input  word_t            wdata,
    input  mask_t            mask,
    output word_t            rdata
);
    word_t mem [ROWS];

    always_ff @(posedge clk) begin
        if (en && wr) begin
            for (int b = 0; b < MASK_W; b++) begin
                if (mask[b]) mem[row][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = mem[row];
endmodule

// File: rtl/cbank_rsp_pipe.sv
// Fixed-depth return pipeline for read beats.
module cbank_rsp_pipe import cbank_pkg::*; #(
    parameter int STAGES = 7
) (
    input  logic      clk,
    input  logic      rst_n,
    input  rsp_beat_t in_beat,
    output rsp_beat_t out_beat
);
    rsp_beat_t stg_d [STAGES];
    rsp_beat_t stg_q [STAGES];

    always_comb begin
        stg_d[0] = in_beat;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign out_beat = stg_q[STAGES-1];
endmodule

// File: rtl/cbank_data_ctrl.sv
module cbank_data_ctrl import cbank_pkg::*; #(
    parameter int NUM_SUB  = 4,
    parameter int NUM_WAYS = 12,
    parameter int ROWS     = 16,
    parameter int LAT      = 8,
    localparam int SUB_W   = $clog2(NUM_SUB),
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int ROW_W   = $clog2(ROWS),
    localparam int NPANEL  = NUM_SUB * NUM_WAYS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [SUB_W-1:0]    req_sub,
    input  logic [WAY_W-1:0]    req_way,
    input  logic [ROW_W-1:0]    req_row,
    input  logic [WORD_W-1:0]   req_wdata,
    input  logic [MASK_W-1:0]   req_mask,
    input  logic [TAG_W-1:0]    req_tag,
    output logic [NUM_SUB-1:0]  sub_en,
    output logic [NPANEL-1:0]   panel_en,
    output logic                rsp_valid,
    output logic [TAG_W-1:0]    rsp_tag,
    output logic [WORD_W-1:0]   rsp_rdata
);
    logic [NUM_SUB-1:0] sub_busy;
    logic [NUM_SUB-1:0] sub_start;
    logic [WAY_W-1:0]   sub_way   [NUM_SUB];
    logic [ROW_W-1:0]   sub_row   [NUM_SUB];
    logic               sub_wr    [NUM_SUB];
    word_t              sub_wdata [NUM_SUB];
    mask_t              sub_mask  [NUM_SUB];
    tag_t               sub_tag   [NUM_SUB];
    word_t              panel_rd  [NUM_SUB][NUM_WAYS];
    rsp_beat_t          done_beat;
    rsp_beat_t          ret_beat;

    // a sub-bank is closed for the cycle in which its access runs
    assign req_ready = !sub_busy[req_sub];
    assign sub_en    = sub_busy;

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        assign sub_start[s] = req_valid && req_ready && (req_sub == SUB_W'(s));

        cbank_subctl #(.WAY_W(WAY_W), .ROW_W(ROW_W)) ctl_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (sub_start[s]),
            .in_way   (req_way),
            .in_row   (req_row),
            .in_wr    (req_write),
            .in_wdata (req_wdata),
            .in_mask  (req_mask),
            .in_tag   (req_tag),
            .busy     (sub_busy[s]),
            .way      (sub_way[s]),
            .row      (sub_row[s]),
            .wr       (sub_wr[s]),
            .wdata    (sub_wdata[s]),
            .mask     (sub_mask[s]),
            .tag      (sub_tag[s])
        );

        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            assign panel_en[s*NUM_WAYS + w] = sub_busy[s] && (sub_way[s] == WAY_W'(w));

            cbank_panel #(.ROWS(ROWS), .ROW_W(ROW_W)) panel_i (
                .clk   (clk),
                .en    (panel_en[s*NUM_WAYS + w]),
                .wr    (sub_wr[s]),
                .row   (sub_row[s]),
                .wdata (sub_wdata[s]),
                .mask  (sub_mask[s]),
                .rdata (panel_rd[s][w])
            );
        end
    end

    // completing read of the active sub-bank enters the return pipeline
    always_comb begin
        done_beat = '0;
        for (int s = 0; s < NUM_SUB; s++) begin
            if (sub_busy[s] && !sub_wr[s]) begin
                done_beat.valid = 1'b1;
                done_beat.tag   = sub_tag[s];
                done_beat.data  = panel_rd[s][sub_way[s]];
            end
        end
    end

    cbank_rsp_pipe #(.STAGES(LAT - 1)) pipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_beat  (done_beat),
        .out_beat (ret_beat)
    );

    assign rsp_valid = ret_beat.valid;
    assign rsp_tag   = ret_beat.tag;
    assign rsp_rdata = ret_beat.data;
endmodule

// File: rtl/cbank_data_ctrl_chk.sv
module cbank_data_ctrl_chk #(
    parameter int NUM_SUB  = 4,
    parameter int NUM_WAYS = 12,
    localparam int SUB_W   = $clog2(NUM_SUB),
    localparam int NPANEL  = NUM_SUB * NUM_WAYS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [SUB_W-1:0]   req_sub,
    input logic [NUM_SUB-1:0] sub_en,
    input logic [NPANEL-1:0]  panel_en
);
    for (genvar s = 0; s < NUM_SUB; s++) begin : g_s
        // R2
        panel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(panel_en[s*NUM_WAYS +: NUM_WAYS]) &&
            (sub_en[s] == (|panel_en[s*NUM_WAYS +: NUM_WAYS])));

        // R2
        accept_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_ready && (req_sub == SUB_W'(s))) |=> sub_en[s]);

        // R3
        release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sub_en[s] |=> !sub_en[s]);
    end

    // R6
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> (sub_en == '0));

    // R5
    single_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_en));
endmodule

bind cbank_data_ctrl cbank_data_ctrl_chk #(.NUM_SUB(NUM_SUB), .NUM_WAYS(NUM_WAYS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_sub   (req_sub),
    .sub_en    (sub_en),
    .panel_en  (panel_en)
);

// File: tb/cbank_data_ctrl_tb_top.sv
`timescale 1ns/1ps
module cbank_data_ctrl_tb_top;
    import cbank_pkg::*;

    localparam int NS  = 4;
    localparam int NW  = 12;
    localparam int NR  = 16;
    localparam int LAT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_sub = '0;
    logic [3:0]    req_way = '0;
    logic [3:0]    req_row = '0;
    word_t         req_wdata = '0;
    mask_t         req_mask = '0;
    tag_t          req_tag = '0;
    logic [NS-1:0] sub_en;
    logic [NS*NW-1:0] panel_en;
    logic          rsp_valid;
    tag_t          rsp_tag;
    word_t         rsp_rdata;

    cbank_data_ctrl #(.NUM_SUB(NS), .NUM_WAYS(NW), .ROWS(NR), .LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_sub(req_sub), .req_way(req_way), .req_row(req_row),
        .req_wdata(req_wdata), .req_mask(req_mask), .req_tag(req_tag),
        .sub_en(sub_en), .panel_en(panel_en),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_rdata(rsp_rdata)
    );

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    word_t model [NS][NW][NR];

    typedef struct {
        int    due;
        tag_t  tag;
        word_t data;
        string rq;
    } exp_t;
    exp_t q[$];

    int last_acc = -10;
    int last_sub = 0;
    int last_way = 0;
    tag_t tag_ctr = 8'h01;

    task automatic chk(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic word_t pat(int s, int w, int r, int salt);
        return {32'(s * 1000 + w * 37 + r + salt), 32'((salt * 7919) ^ r),
                32'((w << 8) | s), 32'(32'hA5A50000 + salt)};
    endfunction

    // driver: presents one request in one cycle, predicts acceptance, feeds scoreboard
    task automatic issue(int s, int w, int r, bit wr, word_t d, mask_t m, string rq);
        bit exp_rdy;
        bit got;
        tag_t t;
        t = tag_ctr;
        tag_ctr = tag_ctr + 8'd1;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_sub   = 2'(s);
        req_way   = 4'(w);
        req_row   = 4'(r);
        req_wdata = d;
        req_mask  = m;
        req_tag   = t;
        exp_rdy   = !(last_acc == cyc && last_sub == s);
        #1;
        got = req_ready;
        chk(got == exp_rdy, exp_rdy ? ((last_acc == cyc) ? "R5" : rq) : "R4", "ready", 128'(got), 128'(exp_rdy));
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (exp_rdy) begin
            last_acc = cyc;
            last_sub = s;
            last_way = w;
            if (wr) begin
                for (int b = 0; b < MASK_W; b++)
                    if (m[b]) model[s][w][r][8*b +: 8] = d[8*b +: 8];
            end else begin
                q.push_back('{due: cyc + LAT - 1, tag: t, data: model[s][w][r], rq: rq});
            end
        end
    endtask

    // monitor: enables and responses, sampled at the falling edge
    always @(negedge clk) begin
        if (running) begin
            logic [NS-1:0]    es;
            logic [NS*NW-1:0] ep;
            es = '0;
            ep = '0;
            if (last_acc == cyc) begin
                es[last_sub] = 1'b1;
                ep[last_sub * NW + last_way] = 1'b1;
            end
            chk(sub_en == es, (es != 0) ? "R2" : "R3", "sub_en", 128'(sub_en), 128'(es));
            chk(panel_en == ep, (ep != 0) ? "R2" : "R3", "panel_en", 128'(panel_en), 128'(ep));
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected response", 128'(rsp_tag), 128'(0));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.due, "R7", "response cycle", 128'(cyc), 128'(e.due));
                    chk(rsp_tag == e.tag, "R7", "response tag", 128'(rsp_tag), 128'(e.tag));
                    chk(rsp_rdata == e.data, e.rq, "read data", rsp_rdata, e.data);
                end
            end else if (q.size() != 0 && q[0].due <= cyc) begin
                chk(1'b0, "R7", "missing response", 128'(0), 128'(q[0].tag));
                void'(q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        #1;
        chk(sub_en == '0, "R1", "sub_en", 128'(sub_en), 128'(0));
        chk(panel_en == '0, "R1", "panel_en", 128'(panel_en), 128'(0));
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", 128'(rsp_valid), 128'(0));
        chk(req_ready == 1'b1, "R1", "req_ready", 128'(req_ready), 128'(1));
        running = 1'b1;

        // fill: rotating sub-banks, one per cycle (R5, R9)
        for (int i = 0; i < 48; i++)
            issue(i % NS, (i * 5) % NW, (i * 3) % NR, 1'b1, pat(i % NS, (i * 5) % NW, (i * 3) % NR, i), '1, "R5");
        // read back on consecutive cycles (R10)
        for (int i = 0; i < 48; i++)
            issue(i % NS, (i * 5) % NW, (i * 3) % NR, 1'b0, '0, '0, "R10");
        repeat (LAT + 2) @(negedge clk);

        // interlock: second write to the same sub-bank is refused (R4, R6)
        issue(0, 3, 5, 1'b1, pat(9, 9, 9, 100), '1, "R4");
        issue(0, 3, 5, 1'b1, pat(8, 8, 8, 200), '1, "R6");
        issue(0, 3, 5, 1'b0, '0, '0, "R6");
        issue(1, 3, 5, 1'b0, '0, '0, "R5");
        repeat (LAT + 2) @(negedge clk);

        // masked write touches only the addressed bytes and panel (R8)
        issue(1, 11, 9, 1'b1, pat(1, 11, 9, 300), '1, "R8");
        issue(1, 10, 9, 1'b1, pat(1, 10, 9, 301), '1, "R8");
        issue(2, 11, 9, 1'b1, pat(2, 11, 9, 302), '1, "R8");
        issue(1, 11, 9, 1'b1, ~pat(1, 11, 9, 300), 16'h00F0, "R8");
        issue(3, 0, 0, 1'b0, '0, '0, "R8");
        issue(1, 11, 9, 1'b0, '0, '0, "R8");
        issue(2, 11, 9, 1'b0, '0, '0, "R8");
        issue(1, 10, 9, 1'b0, '0, '0, "R8");
        issue(3, 1, 1, 1'b1, pat(3, 1, 1, 303), 16'h8001, "R8");
        issue(3, 1, 1, 1'b0, '0, '0, "R8");
        repeat (LAT + 2) @(negedge clk);

        // streak to one sub-bank: refusals alternate with acceptances (R4, R6)
        for (int i = 0; i < 8; i++)
            issue(2, i % NW, (i * 3) % NR, 1'b0, '0, '0, "R4");
        for (int i = 0; i < 6; i++)
            issue(0, 7, 2, 1'b1, pat(0, 7, 2, 400 + i), 16'h0F0F, "R6");
        issue(0, 7, 2, 1'b0, '0, '0, "R6");

        repeat (LAT + 4) @(negedge clk);
        chk(q.size() == 0, "R7", "pending responses", 128'(q.size()), 128'(0));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule